// File: doc/BRIEF.md
# Audio Interface Master Clock Generator

This block derives the serial bit clock and two independent frame (word-select) clocks, one for the ADC path and one for the DAC path, from the master clock while the audio interface is the clock master. Each frame clock has its own 3-bit ratio select that gives the number of master-clock cycles per frame. The bit clock always runs at 64 periods per frame of the DAC path, so its master-clock divisor is the DAC ratio divided by 64.

When the interface is a clock slave, the three clock pins are inputs at the chip boundary. The block then drives its three clock outputs low and deasserts all three output enables. The dividers are held at their start phase so that the first master-mode cycle is the first cycle of a frame. A change on either ratio select also restarts all three dividers at the edge where the change is seen, so the next frame starts cleanly.

Top module: `acg_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the three clock outputs and the three output enables are low.
- R2: When `master_en` is sampled low at a rising edge, the three enables are low and the three clock outputs are low from that edge. When it is sampled high, the enables are high from that edge.
- R3: Ratio codes map to master-clock cycles per frame as follows: 000 = 128, 001 = 192, 010 = 256, 011 = 384, 100 = 512, 101 = 768. The bit clock period in master-clock cycles is the DAC frame length divided by 64, giving 2, 3, 4, 6, 8 or 12.
- R4: The DAC frame clock has a period equal to the DAC frame length. It is low for the first half and high for the second half, counted from the restart edge.
- R5: The ADC frame clock follows its own select with the same encoding and the same 50% shape as R4, independent of the DAC select.
- R6: Within one bit clock period of D master cycles, the bit clock is low for D - floor(D/2) cycles and then high for floor(D/2) cycles. For D = 3 it is high for 1 cycle and low for 2.
- R7: Outside a restart, every change of the DAC frame clock happens on the same edge as a falling edge of the bit clock.
- R8: Reserved ratio codes 110 and 111 behave exactly as 010 (256 cycles per frame).
- R9: A change on either ratio select, seen at a rising edge, restarts all three dividers at phase 0 on that edge, using the new selects.
- R10: On the first edge where `master_en` is sampled high after a slave period, all three dividers are at phase 0. Phase n after that edge gives bit clock = (n mod D) >= D - floor(D/2) and frame clock = (n mod L) >= L/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| master_en | input | 1 | 1 = interface is clock master, 0 = slave |
| adc_sel | input | 3 | ADC frame ratio select |
| dac_sel | input | 3 | DAC frame ratio select, also sets the bit clock |
| bclk_o | output | 1 | Generated bit clock |
| adc_fclk_o | output | 1 | Generated ADC frame clock |
| dac_fclk_o | output | 1 | Generated DAC frame clock |
| bclk_oe | output | 1 | Output enable for the bit clock pin |
| adc_fclk_oe | output | 1 | Output enable for the ADC frame clock pin |
| dac_fclk_oe | output | 1 | Output enable for the DAC frame clock pin |

## Verification
The bench targets the divide-by-3 ratio. An even-only duty rule would hold that bit clock high for 2 cycles, or give it a period of 2 or 4. It also applies mismatched ADC and DAC selects. A design that derived the bit clock from the ADC select, or shared one frame counter between the two paths, would then show the wrong period on one pin. The reserved codes are expected to act as 256. A select change in the middle of a frame must restart every divider on that edge; a design that waited for the frame end or left the other path running would miscompare on the next cycles. The first master cycle after slave mode is checked for phase 0, which catches an off-by-one start.

// File: rtl/acg_pkg.sv
package acg_pkg;

   localparam int SEL_W      = 3;
   localparam int BDIV_W     = 4;
   localparam int MAX_BDIV   = 12;
   localparam logic [SEL_W-1:0] SEL_DEFAULT = 3'b010;

   typedef logic [SEL_W-1:0]  sel_t;
   typedef logic [BDIV_W-1:0] bdiv_t;

   // master-clock cycles per bit clock period for a ratio code
   function automatic bdiv_t bclk_div(input sel_t sel);
      bdiv_t d;
      case (sel)
         3'b000:  d = 4'd2;
         3'b001:  d = 4'd3;
         3'b010:  d = 4'd4;
         3'b011:  d = 4'd6;
         3'b100:  d = 4'd8;
         3'b101:  d = 4'd12;
         default: d = 4'd4;
      endcase
      return d;
   endfunction

endpackage

// File: rtl/acg_phase_div.sv
module acg_phase_div #(
   parameter int W = 10
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic [W-1:0] limit,
   input  logic [W-1:0] thresh,
   output logic         out_q
);

   logic [W-1:0] ph_q;
   logic [W-1:0] ph_nxt;

   initial begin
      if (W < 2) $error("acg_phase_div: W must be at least 2");
   end

   always_comb begin
      if (restart)
         ph_nxt = '0;
      else if (ph_q == limit - W'(1))
         ph_nxt = '0;
      else
         ph_nxt = ph_q + W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ph_q  <= '0;
         out_q <= 1'b0;
      end else begin
         ph_q  <= ph_nxt;
         out_q <= (ph_nxt >= thresh);
      end
   end

   // R3
   ph_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ph_q < limit);

endmodule

// File: rtl/acg_sel_watch.sv
module acg_sel_watch
   import acg_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic master_en,
   input  sel_t adc_sel,
   input  sel_t dac_sel,
   output sel_t adc_sel_q,
   output sel_t dac_sel_q,
   output logic oe_q,
   output logic restart
);

   logic sel_moved;

   assign sel_moved = (adc_sel != adc_sel_q) || (dac_sel != dac_sel_q);
   assign restart   = !master_en || !oe_q || sel_moved;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         adc_sel_q <= SEL_DEFAULT;
         dac_sel_q <= SEL_DEFAULT;
         oe_q      <= 1'b0;
      end else begin
         adc_sel_q <= adc_sel;
         dac_sel_q <= dac_sel;
         oe_q      <= master_en;
      end
   end

endmodule

// File: rtl/acg_top.sv
module acg_top
   import acg_pkg::*;
#(
   parameter int BCLK_PER_FRAME = 64
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       master_en,
   input  logic [2:0] adc_sel,
   input  logic [2:0] dac_sel,
   output logic       bclk_o,
   output logic       adc_fclk_o,
   output logic       dac_fclk_o,
   output logic       bclk_oe,
   output logic       adc_fclk_oe,
   output logic       dac_fclk_oe
);

   localparam int FW = $clog2(MAX_BDIV * BCLK_PER_FRAME + 1);
   localparam int NFRM = 2;

   if (BCLK_PER_FRAME < 2 || (BCLK_PER_FRAME % 2) != 0) begin : g_bad_bpf
      $error("acg_top: BCLK_PER_FRAME must be even and at least 2");
   end

   sel_t  adc_sel_q, dac_sel_q;
   logic  oe_q;
   logic  restart;
   bdiv_t bdiv;
   logic  fclk [NFRM];

   acg_sel_watch u_watch (
      .clk       (clk),
      .rst_n     (rst_n),
      .master_en (master_en),
      .adc_sel   (adc_sel),
      .dac_sel   (dac_sel),
      .adc_sel_q (adc_sel_q),
      .dac_sel_q (dac_sel_q),
      .oe_q      (oe_q),
      .restart   (restart)
   );

   assign bdiv = bclk_div(dac_sel_q);

   acg_phase_div #(.W(BDIV_W)) u_bclk_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (restart),
      .limit   (bdiv),
      .thresh  (bdiv - (bdiv >> 1)),
      .out_q   (bclk_o)
   );

   // index 0 = ADC path, index 1 = DAC path
   for (genvar i = 0; i < NFRM; i++) begin : g_frame
      sel_t          fsel;
      logic [FW-1:0] flen;
      assign fsel = (i == 0) ? adc_sel_q : dac_sel_q;
      assign flen = FW'(bclk_div(fsel)) * FW'(BCLK_PER_FRAME);
      acg_phase_div #(.W(FW)) u_fdiv (
         .clk     (clk),
         .rst_n   (rst_n),
         .restart (restart),
         .limit   (flen),
         .thresh  (flen >> 1),
         .out_q   (fclk[i])
      );
   end

   assign adc_fclk_o  = fclk[0];
   assign dac_fclk_o  = fclk[1];
   assign bclk_oe     = oe_q;
   assign adc_fclk_oe = oe_q;
   assign dac_fclk_oe = oe_q;

   // R2
   oe_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bclk_oe |-> (!bclk_o && !adc_fclk_o && !dac_fclk_o));

   // R7
   fall_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bclk_oe && $past(bclk_oe) && !$past(restart)
       && (dac_fclk_o != $past(dac_fclk_o))) |-> $fell(bclk_o));

   // R6
   div3_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dac_sel_q == 3'b001 && bclk_o) |=> !bclk_o);

endmodule

// File: tb/tb_acg_top.sv
module tb_acg_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       master_en = 1'b0;
   logic [2:0] adc_sel = 3'b010;
   logic [2:0] dac_sel = 3'b010;
   logic       bclk_o, adc_fclk_o, dac_fclk_o;
   logic       bclk_oe, adc_fclk_oe, dac_fclk_oe;

   int nchk = 0;
   int nfail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   acg_top dut (
      .clk(clk), .rst_n(rst_n), .master_en(master_en),
      .adc_sel(adc_sel), .dac_sel(dac_sel),
      .bclk_o(bclk_o), .adc_fclk_o(adc_fclk_o), .dac_fclk_o(dac_fclk_o),
      .bclk_oe(bclk_oe), .adc_fclk_oe(adc_fclk_oe), .dac_fclk_oe(dac_fclk_oe)
   );

   // {adc_sel, dac_sel}
   localparam logic [5:0] VEC [8] = '{
      {3'd2, 3'd2}, {3'd0, 3'd0}, {3'd1, 3'd1}, {3'd3, 3'd5},
      {3'd5, 3'd4}, {3'd4, 3'd3}, {3'd6, 3'd1}, {3'd0, 3'd7}
   };

   function automatic int div_of(input logic [2:0] s);
      case (s)
         3'd0: return 2;
         3'd1: return 3;
         3'd3: return 6;
         3'd4: return 8;
         3'd5: return 12;
         default: return 4;
      endcase
   endfunction

   task automatic check(input string tag, input logic [5:0] got, input logic [5:0] exp);
      nchk++;
      if (got !== exp) begin
         nfail++;
         $display("FAIL %s: got %b expected %b (bclk,adc,dac,oe x3)", tag, got, exp);
      end
   endtask

   // phase n after restart, sampled at the negedge following the restart edge
   task automatic check_phase(input string tag, input int n, input logic [2:0] a, input logic [2:0] d);
      int bd = div_of(d);
      int la = div_of(a) * 64;
      int ld = div_of(d) * 64;
      logic [5:0] exp;
      exp = {((n % bd) >= bd - bd / 2), ((n % la) >= la / 2), ((n % ld) >= ld / 2), 3'b111};
      check(tag, {bclk_o, adc_fclk_o, dac_fclk_o, bclk_oe, adc_fclk_oe, dac_fclk_oe}, exp);
   endtask

   task automatic start_run(input logic [2:0] a, input logic [2:0] d);
      @(negedge clk);
      master_en = 1'b0;
      @(negedge clk);
      adc_sel = a;
      dac_sel = d;
      master_en = 1'b1;
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         nfail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
         $finish;
      end
   end

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      check("R1 in reset", {bclk_o, adc_fclk_o, dac_fclk_o, bclk_oe, adc_fclk_oe, dac_fclk_oe}, 6'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 after reset", {bclk_o, adc_fclk_o, dac_fclk_o, bclk_oe, adc_fclk_oe, dac_fclk_oe}, 6'b0);

      // R3 R4 R5 R6 R8 R10: table walk
      foreach (VEC[v]) begin
         logic [2:0] a = VEC[v][5:3];
         logic [2:0] d = VEC[v][2:0];
         int span = 2 * ((div_of(a) > div_of(d)) ? div_of(a) : div_of(d)) * 64 + 7;
         string tag = (a > 3'd5 || d > 3'd5) ? "R8 reserved" :
                      (d == 3'd1) ? "R6 div3" :
                      (a != d) ? "R5 independent" : "R3 R4 ratio";
         start_run(a, d);
         for (int n = 0; n < span; n++) begin
            @(negedge clk);
            check_phase((n == 0) ? "R10 first phase" : tag, n, a, d);
         end
      end

      // R7: frame edges on bclk falling edges, divide-by-3
      begin
         logic pb, pf;
         int bad = 0;
         start_run(3'd2, 3'd1);
         @(negedge clk);
         pb = bclk_o; pf = dac_fclk_o;
         for (int n = 1; n < 800; n++) begin
            @(negedge clk);
            if (dac_fclk_o != pf && !(pb && !bclk_o)) bad++;
            pb = bclk_o; pf = dac_fclk_o;
         end
         nchk++;
         if (bad != 0) begin
            nfail++;
            $display("FAIL R7: got %0d misaligned frame edges expected 0", bad);
         end
      end

      // R9: change of the ADC select mid-frame restarts every divider
      start_run(3'd2, 3'd2);
      for (int n = 0; n < 90; n++) begin
         @(negedge clk);
         check_phase("R9 before change", n, 3'd2, 3'd2);
      end
      adc_sel = 3'd0;
      for (int n = 0; n < 300; n++) begin
         @(negedge clk);
         check_phase("R9 after adc change", n, 3'd0, 3'd2);
      end
      // R9: change of the DAC select mid-frame
      dac_sel = 3'd1;
      for (int n = 0; n < 400; n++) begin
         @(negedge clk);
         check_phase("R9 after dac change", n, 3'd0, 3'd1);
      end

      // R2: slave mode drops enables and clocks at the next edge
      master_en = 1'b0;
      for (int n = 0; n < 5; n++) begin
         @(negedge clk);
         check("R2 slave", {bclk_o, adc_fclk_o, dac_fclk_o, bclk_oe, adc_fclk_oe, dac_fclk_oe}, 6'b0);
      end
      master_en = 1'b1;
      for (int n = 0; n < 20; n++) begin
         @(negedge clk);
         check_phase("R2 back to master", n, 3'd0, 3'd1);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule